// File: doc/BRIEF.md
# Station Address Filter

This block keeps the node's own 48-bit station address and checks the destination field of every received frame against it. The host loads and reads the address through a byte-wide register port. The port has two locations. The control location holds an address-select bit and an address-change request bit. The data location steps through the six address bytes using an internal pointer.

The receive path sends destination bytes in wire order. The first byte is flagged with a start-of-frame strobe. One cycle after the sixth destination byte, the block reports whether the frame is addressed to this station. Until the receiver has been enabled for the first time, the host may reach the address freely.

After that, access needs a handshake. The host sets the change request and polls it. The hardware clears the request only when no destination field is being compared. That clearing is the grant that unlocks the address bytes.

Top module: `station_addr_filter`

## Requirements
- R1: After a synchronous reset, `match` and `match_valid` are 0, the control location reads 0, and all six stored address bytes are 0.
- R2: Before `rx_enable` has ever been high, with address-select set, six successive data-location writes load stored bytes 0 to 5 in order, and six reads return them in the same order. Byte 0 is the first destination byte on the wire.
- R3: Any write to the control location returns the byte pointer to byte 0. Each accepted data access advances the pointer, and the access after byte 5 goes to byte 0.
- R4: While address-select (control bit 0) is clear, data-location writes leave the stored address unchanged, and data-location reads return 0.
- R5: Once `rx_enable` has been high at any time since reset, data-location accesses without a grant are ignored: reads return 0, writes change nothing, and the pointer does not move. This holds even after `rx_enable` falls again.
- R6: Writing the control location with bit 1 set raises the change request, and it reads back as 1. The hardware clears it only in a cycle where no destination field is in progress. The host cannot clear it.
- R7: Clearing the request grants access, and the grant lasts until the host writes the control location with bit 0 clear. After that, data accesses are locked again.
- R8: `match_valid` rises one cycle after the sixth destination byte. At the same time, `match` is 1 exactly when all six bytes equal the stored address, bit 0 of byte 0 is 0, and `match_disable` was low with the sixth byte.
- R9: With `match_disable` high when the sixth destination byte arrives, `match` is 0.
- R10: A destination whose first received bit (bit 0 of byte 0) is 1 never matches, even when it equals the stored address.
- R11: `match` and `match_valid` hold their values through payload bytes. The next start-of-frame byte clears `match_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_is_ctrl | input | 1 | 1 selects the control location, 0 the address-data location |
| host_wdata | input | 8 | Write byte; in control writes bit 0 is address-select and bit 1 is change request |
| host_rdata | output | 8 | Registered read byte; control reads give {0, request, select} |
| rx_enable | input | 1 | Receiver enable |
| match_disable | input | 1 | Suppresses the station match |
| rx_sof | input | 1 | Marks the first destination byte, together with rx_valid |
| rx_valid | input | 1 | Receive byte strobe |
| rx_byte | input | 8 | Received byte, bit 0 first on the wire |
| match | output | 1 | Station address matched |
| match_valid | output | 1 | Match result is valid for the current frame |

## Verification
The hardest case to reach from the ports is a change request that arrives while a destination field is only partly received. Here the grant must wait for the field to finish. The bench runs a slow frame, with idle gaps between bytes, alongside a host thread. The host thread writes the request in the middle of the field and reads the control location back while the field is still in progress. It then polls until the grant appears and checks that the frame's match used the old address. Random addresses and destinations are then run through the full handshake many times. Exact, single-byte-off and group-bit patterns are mixed with random use of the disable input.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int CTRL_SEL_BIT = 0;
  localparam int CTRL_REQ_BIT = 1;
endpackage

// File: rtl/sa_store.sv
module sa_store #(
  parameter int NB = 6,
  parameter int BW = 8,
  localparam int PW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [PW-1:0]   wptr,
  input  logic [BW-1:0]   wdata,
  input  logic [PW-1:0]   host_ptr,
  input  logic [PW-1:0]   cmp_ptr,
  output logic [BW-1:0]   host_byte,
  output logic [BW-1:0]   cmp_byte,
  output logic [NB*BW-1:0] addr_flat
);
  logic [BW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wptr] <= wdata;
    end
  end

  assign host_byte = mem[host_ptr];
  assign cmp_byte  = mem[cmp_ptr];

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_flat
      assign addr_flat[g*BW +: BW] = mem[g];
    end
  endgenerate
endmodule

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int NB = 6,
  parameter int BW = 8,
  localparam int PW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_is_ctrl,
  input  logic [BW-1:0] host_wdata,
  input  logic          rx_enable,
  input  logic          frame_busy,
  input  logic [BW-1:0] store_byte,
  output logic [BW-1:0] host_rdata,
  output logic [PW-1:0] ptr,
  output logic          store_we,
  output logic          seen_en,
  output logic          granted
);
  logic addr_sel, chg_req;
  logic ctrl_wr, ctrl_rd, data_wr, data_rd, access_ok, advance;

  assign ctrl_wr   = host_wr && host_is_ctrl;
  assign ctrl_rd   = host_rd && !host_wr && host_is_ctrl;
  assign data_wr   = host_wr && !host_is_ctrl;
  assign data_rd   = host_rd && !host_wr && !host_is_ctrl;
  assign access_ok = addr_sel && (!seen_en || granted);
  assign store_we  = data_wr && access_ok;
  assign advance   = (data_wr || data_rd) && access_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sel   <= 1'b0;
      chg_req    <= 1'b0;
      granted    <= 1'b0;
      seen_en    <= 1'b0;
      ptr        <= '0;
      host_rdata <= '0;
    end else begin
      if (rx_enable) seen_en <= 1'b1;
      if (chg_req && !frame_busy) begin
        chg_req <= 1'b0;
        granted <= 1'b1;
      end
      if (ctrl_wr) begin
        addr_sel <= host_wdata[CTRL_SEL_BIT];
        if (host_wdata[CTRL_REQ_BIT]) chg_req <= 1'b1;
        if (!host_wdata[CTRL_SEL_BIT]) granted <= 1'b0;
        ptr <= '0;
      end else if (advance) begin
        ptr <= (ptr == PW'(NB-1)) ? '0 : ptr + PW'(1);
      end
      if (ctrl_rd)
        host_rdata <= {{(BW-2){1'b0}}, chg_req, addr_sel};
      else if (data_rd)
        host_rdata <= access_ok ? store_byte : '0;
    end
  end

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(NB-1));

  // R6
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(chg_req) |-> !$past(frame_busy));

  // R5
  seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(seen_en) |-> seen_en);
endmodule

// File: rtl/sa_compare.sv
module sa_compare #(
  parameter int NB = 6,
  parameter int BW = 8,
  localparam int PW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_sof,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  input  logic          match_disable,
  input  logic [BW-1:0] st_byte,
  output logic [PW-1:0] cmp_idx,
  output logic          busy,
  output logic          match,
  output logic          match_valid
);
  logic          active, eq, grp;
  logic [PW-1:0] idx;
  logic          first, cont, hit;

  assign first   = rx_valid && rx_sof;
  assign cont    = rx_valid && !rx_sof && active;
  assign cmp_idx = first ? '0 : idx;
  assign hit     = (rx_byte == st_byte);
  assign busy    = active || first;

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      eq          <= 1'b0;
      grp         <= 1'b0;
      idx         <= '0;
      match       <= 1'b0;
      match_valid <= 1'b0;
    end else if (first) begin
      match_valid <= 1'b0;
      match       <= 1'b0;
      eq          <= hit && !rx_byte[0];
      grp         <= rx_byte[0];
      idx         <= PW'(1);
      active      <= 1'b1;
    end else if (cont) begin
      eq  <= eq && hit;
      idx <= idx + PW'(1);
      if (idx == PW'(NB-1)) begin
        active      <= 1'b0;
        idx         <= '0;
        match_valid <= 1'b1;
        match       <= eq && hit && !match_disable;
      end
    end
  end

  // R8
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    match |-> match_valid);

  // R9
  disable_kills_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(match_valid) && $past(match_disable)) |-> !match);

  // R10
  group_never_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(match_valid) && grp) |-> !match);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (match_valid && !first) |=> (match_valid && $stable(match)));
endmodule

// File: rtl/station_addr_filter.sv
module station_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_is_ctrl,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              rx_enable,
  input  logic              match_disable,
  input  logic              rx_sof,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              match,
  output logic              match_valid
);
  localparam int PW = $clog2(ADDR_BYTES);

  logic [PW-1:0]     host_ptr, cmp_idx;
  logic              store_we, seen_en, granted, frame_busy;
  logic [BYTE_W-1:0] host_byte, cmp_byte;
  logic [ADDR_BYTES*BYTE_W-1:0] station;

  sa_ctrl #(.NB(ADDR_BYTES), .BW(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_is_ctrl(host_is_ctrl),
    .host_wdata(host_wdata), .rx_enable(rx_enable), .frame_busy(frame_busy),
    .store_byte(host_byte), .host_rdata(host_rdata), .ptr(host_ptr),
    .store_we(store_we), .seen_en(seen_en), .granted(granted)
  );

  sa_store #(.NB(ADDR_BYTES), .BW(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .we(store_we), .wptr(host_ptr), .wdata(host_wdata),
    .host_ptr(host_ptr), .cmp_ptr(cmp_idx), .host_byte(host_byte),
    .cmp_byte(cmp_byte), .addr_flat(station)
  );

  sa_compare #(.NB(ADDR_BYTES), .BW(BYTE_W)) u_cmp (
    .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .match_disable(match_disable), .st_byte(cmp_byte),
    .cmp_idx(cmp_idx), .busy(frame_busy), .match(match),
    .match_valid(match_valid)
  );

  // R5
  locked_store_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_is_ctrl && seen_en && !granted) |=> $stable(station));
endmodule

// File: tb/test_station_addr_filter.sv
module test_station_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;

  logic clk = 0, rst = 1;
  logic host_wr = 0, host_rd = 0, host_is_ctrl = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic rx_enable = 0, match_disable = 0, rx_sof = 0, rx_valid = 0;
  logic [7:0] rx_byte = 0;
  logic match, match_valid;

  int errors = 0, checks = 0;
  bit [47:0] model_st = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  station_addr_filter i_station_addr_filter (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_is_ctrl(host_is_ctrl), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_enable(rx_enable), .match_disable(match_disable), .rx_sof(rx_sof),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .match(match), .match_valid(match_valid)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_match(input bit [47:0] d, input bit [47:0] s, input bit dis);
    return !dis && (d == s) && !d[0];
  endfunction

  task automatic host_op(input bit is_ctrl, input bit wr, input bit [7:0] d, output bit [7:0] q);
    @(negedge clk);
    host_is_ctrl = is_ctrl; host_wr = wr; host_rd = !wr; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    q = host_rdata;
  endtask

  task automatic ctrl_write(input bit [7:0] d);
    bit [7:0] q;
    host_op(1'b1, 1'b1, d, q);
  endtask

  task automatic ctrl_read(output bit [7:0] q);
    host_op(1'b1, 1'b0, 8'h00, q);
  endtask

  task automatic data_write(input bit [7:0] d);
    bit [7:0] q;
    host_op(1'b0, 1'b1, d, q);
  endtask

  task automatic data_read(output bit [7:0] q);
    host_op(1'b0, 1'b0, 8'h00, q);
  endtask

  task automatic send_frame(input bit [47:0] d, input int gap);
    for (int i = 0; i < NB; i++) begin
      if (i > 0) begin
        repeat (gap) begin
          @(negedge clk); rx_valid = 0; rx_sof = 0;
        end
      end
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_byte = d[8*i +: 8];
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0;
  endtask

  task automatic frame_check(input string tag, input bit [47:0] d, input bit dis, input int gap);
    match_disable = dis;
    send_frame(d, gap);
    chk({tag, " match_valid"}, match_valid, 1'b1);
    chk({tag, " match"}, match, exp_match(d, model_st, dis));
    match_disable = 0;
  endtask

  task automatic grant_request(input string tag);
    bit [7:0] q;
    ctrl_write(8'h02);
    q = 8'h02;
    for (int n = 0; n < 40 && q[1]; n++) ctrl_read(q);
    chk({tag, " R6 request cleared"}, q[1], 1'b0);
    ctrl_write(8'h01);
  endtask

  task automatic load_addr(input bit [47:0] a);
    grant_request("load");
    for (int i = 0; i < NB; i++) data_write(a[8*i +: 8]);
    ctrl_write(8'h00);
    model_st = a;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit [7:0] q;
    bit [47:0] a, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 match", match, 1'b0);
    chk("R1 match_valid", match_valid, 1'b0);
    ctrl_read(q);
    chk("R1 ctrl", q, 8'h00);
    ctrl_write(8'h01);
    for (int i = 0; i < NB; i++) begin
      data_read(q);
      chk("R1 stored byte zero", q, 8'h00);
    end

    // R2 load before enable, read back
    a = 48'h5a_34_12_cd_ab_02;
    ctrl_write(8'h01);
    for (int i = 0; i < NB; i++) data_write(a[8*i +: 8]);
    model_st = a;
    ctrl_write(8'h01);
    for (int i = 0; i < NB; i++) begin
      data_read(q);
      chk("R2 readback", q, a[8*i +: 8]);
    end
    // R3 wrap after byte 5
    data_read(q);
    chk("R3 wrap to byte0", q, a[7:0]);
    data_read(q);
    ctrl_write(8'h01);
    data_read(q);
    chk("R3 ctrl write resets pointer", q, a[7:0]);

    // R4 select clear: ignored
    ctrl_write(8'h00);
    data_write(8'hff);
    data_read(q);
    chk("R4 read without select", q, 8'h00);
    ctrl_write(8'h01);
    data_read(q);
    chk("R4 write without select ignored", q, a[7:0]);
    ctrl_write(8'h00);

    // R8 match before and after enable
    frame_check("R8 exact", a, 0, 0);
    d = a; d[23:16] = d[23:16] ^ 8'h10;
    frame_check("R8 one byte off", d, 0, 1);
    rx_enable = 1;
    frame_check("R9 disabled", a, 1, 0);
    frame_check("R8 exact gapped", a, 0, 2);

    // R11 hold through payload
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_byte = 8'($urandom);
    end
    @(negedge clk); rx_valid = 0;
    chk("R11 match held", match, 1'b1);
    chk("R11 valid held", match_valid, 1'b1);
    @(negedge clk); rx_valid = 1; rx_sof = 1; rx_byte = a[7:0];
    @(negedge clk); rx_valid = 0; rx_sof = 0;
    chk("R11 sof clears valid", match_valid, 1'b0);
    for (int i = 1; i < NB; i++) begin
      @(negedge clk); rx_valid = 1; rx_byte = a[8*i +: 8];
    end
    @(negedge clk); rx_valid = 0;
    chk("R11 result after second frame", match, 1'b1);

    // R5 locked after enable, even when enable drops
    ctrl_write(8'h01);
    data_write(8'h77);
    data_read(q);
    chk("R5 locked read", q, 8'h00);
    rx_enable = 0;
    data_read(q);
    chk("R5 locked after enable fell", q, 8'h00);
    ctrl_write(8'h00);
    frame_check("R5 address unchanged", a, 0, 0);

    // R6 request deferred while a destination field is in progress
    rx_enable = 1;
    fork
      frame_check("R6 frame during request", a, 0, 4);
      begin
        repeat (3) @(negedge clk);
        ctrl_write(8'h02);
        ctrl_read(q);
        chk("R6 request held mid-field", q[1], 1'b1);
      end
    join
    q = 8'h02;
    for (int n = 0; n < 20 && q[1]; n++) ctrl_read(q);
    chk("R6 request granted after field", q[1], 1'b0);

    // R7 granted access, then relock
    ctrl_write(8'h01);
    data_read(q);
    chk("R7 granted read", q, a[7:0]);
    ctrl_write(8'h00);
    ctrl_write(8'h01);
    data_read(q);
    chk("R7 relocked after select clear", q, 8'h00);
    ctrl_write(8'h00);

    // R10 group bit
    a = 48'h11_22_33_44_55_67;
    load_addr(a);
    frame_check("R10 group exact", a, 0, 0);

    // random
    for (int it = 0; it < 30; it++) begin
      a = {16'($urandom), 32'($urandom)};
      if ($urandom_range(0, 3) != 0) a[0] = 1'b0;
      load_addr(a);
      grant_request("R7 verify");
      for (int i = 0; i < NB; i++) begin
        data_read(q);
        chk("R7 random readback", q, a[8*i +: 8]);
      end
      ctrl_write(8'h00);
      for (int f = 0; f < 4; f++) begin
        int kind;
        kind = $urandom_range(0, 3);
        d = a;
        if (kind == 1) d[8*$urandom_range(0, 5) +: 8] ^= 8'(1 << $urandom_range(0, 7));
        if (kind == 2) d[0] = 1'b1;
        if (kind == 3) d = {16'($urandom), 32'($urandom)};
        frame_check("R8 random", d, ($urandom_range(0, 3) == 0), $urandom_range(0, 2));
      end
    end

    finish_run();
  end
endmodule